// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the multiplexed external memory bus of an 8-bit controller whose machine cycle lasts twelve oscillator clocks. It produces the address latch strobe, the program-store read strobe and the data read and write strobes. It also drives the shared low address/data port and the high address port. The clock input is the oscillator clock. A free-running phase counter splits each machine cycle into two halves of six clocks.

A machine cycle is either a program fetch cycle or a data access cycle. In a fetch cycle each half latches a fetch address and, when external fetching is enabled, strobes one code byte in. A data access cycle replaces the whole machine cycle. It keeps the first address latch pulse for the data address, drops the second pulse and both program-store strobes, and runs one long read or write strobe. The high port carries either the upper address byte or the value of the port register, depending on whether the access uses 16-bit or 8-bit addressing. The byte read during the last clock of any read strobe is held on a capture output together with a one-clock valid flag.

Top module: `bus_seq`

## Requirements
- R1: In a fetch cycle `ale` is high in phases 0-1 and 6-7 and low in every other phase. It therefore pulses every 6 clocks, and each pulse lasts 2 clocks.
- R2: When `ext_fetch` was high at the half-cycle latch point, `psen_n` is low in phases 3-5 of that half (3-5 or 9-11 of the cycle). When it was low, `psen_n` stays high for that half.
- R3: A request with `req_valid` high at the clock edge that ends phase 11 makes the next machine cycle a data access cycle. In that cycle `ale` is high only in phases 0-1, and `psen_n` stays high in all 12 phases.
- R4: In a data access cycle the strobe (`rd_n` when `req_write`=0, `wr_n` when `req_write`=1) is low in phases 5-10. It falls 3 clocks after `ale` falls and stays low for 6 clocks. The other strobe stays high.
- R5: `lo_oe` is high with the latched address low byte on `lo_out` in phases 0-2 (and 6-8 in a fetch cycle). In a write cycle, `lo_out` carries the write byte with `lo_oe` high in phases 3-11. In every other phase `lo_oe` is low.
- R6: In a data access cycle, `hi_out` holds `req_addr[15:8]` when `req_wide`=1 and holds `port_hi` when `req_wide`=0, both sampled with the request. It stays constant for all 12 phases.
- R7: A fetch byte on `lo_in` is captured at the edge ending phase 5 or 11 and reported in phase 6 or 0, with `cap_valid`=1 and `cap_code`=1. A read byte is captured at the edge ending phase 10 and reported in phase 11, with `cap_valid`=1 and `cap_code`=0. `cap_valid` is 0 in all other phases.
- R8: While `rst_n` is low: `psen_n`, `rd_n` and `wr_n` are 1, `cap_valid` is 0, and the sequencer sits in phase 0 of a fetch cycle with address 0 and `ale`=1. The phase counter starts running on the third rising edge after `rst_n` rises.
- R9: In a fetch cycle, the second half uses the `fetch_addr` and `ext_fetch` values sampled at the edge that ends phase 5. The first half uses the values sampled at the edge that ends phase 11 of the previous cycle. In both halves `hi_out` carries `fetch_addr[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fetch | input | 1 | Program fetches go to external memory |
| fetch_addr | input | 16 | Program fetch address |
| req_valid | input | 1 | Data access wanted in the next machine cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address with port register on high port |
| req_addr | input | 16 | Data access address |
| req_wdata | input | 8 | Write byte |
| port_hi | input | 8 | High port register contents |
| lo_in | input | 8 | Low port pad input |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | 8 | High port drive value |
| rdata | output | 8 | Last captured byte |
| cap_valid | output | 1 | Capture reported this clock |
| cap_code | output | 1 | Capture came from a program fetch |

## Verification
The edge that ends phase 11 does two jobs at once. It captures the second-half code byte of an external fetch cycle, and it latches the request that turns the next cycle into a data access. The bench arms a read or write request during an external fetch cycle to provoke this. In phase 0 of the data cycle it then checks that the reported byte is the code byte driven in phases 9-11 and that `ale`, `lo_out` and `hi_out` already present the data address. A read followed at once by a write also makes the read capture and the write request latch fall in adjacent clocks of the same cycle. Both results are checked phase by phase.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  // machine cycle geometry
  localparam int MC_LEN    = 12;
  localparam int HALF_LEN  = MC_LEN / 2;
  localparam int PH_W      = $clog2(MC_LEN);
  // strobe timing, in oscillator clocks
  localparam int ALE_HI    = 2;  // latch strobe high time
  localparam int ADDR_HOLD = 1;  // address kept after latch strobe falls
  localparam int PS_LEN    = 3;  // program-store strobe low time
  localparam int STB_LAG   = 3;  // latch fall to read/write fall
  localparam int STB_LEN   = 6;  // read/write low time

  typedef logic [PH_W-1:0] phase_t;
  typedef enum logic [1:0] {CYC_FETCH = 2'd0, CYC_RD = 2'd1, CYC_WR = 2'd2} cyc_e;

  localparam phase_t P_ALE_OFF  = phase_t'(ALE_HI);
  localparam phase_t P_ADDR_OFF = phase_t'(ALE_HI + ADDR_HOLD);
  localparam phase_t P_PS_OFF   = phase_t'(ALE_HI + ADDR_HOLD + PS_LEN);
  localparam phase_t P_PS_LAST  = phase_t'(ALE_HI + ADDR_HOLD + PS_LEN - 1);
  localparam phase_t P_STB_ON   = phase_t'(ALE_HI + STB_LAG);
  localparam phase_t P_STB_OFF  = phase_t'(ALE_HI + STB_LAG + STB_LEN);
  localparam phase_t P_STB_LAST = phase_t'(ALE_HI + STB_LAG + STB_LEN - 1);
  localparam phase_t P_HALF     = phase_t'(HALF_LEN);
  localparam phase_t P_MID      = phase_t'(HALF_LEN - 1);
  localparam phase_t P_LAST     = phase_t'(MC_LEN - 1);
endpackage

// File: rtl/bus_seq_phase.sv
module bus_seq_phase
  import bus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_i,
  output phase_t ph,
  output phase_t hp,
  output logic   upper,
  output logic   last,
  output logic   mid
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q + phase_t'(1);
    if (ph_q == P_LAST) ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph    = ph_q;
  assign upper = (ph_q >= P_HALF);
  assign hp    = upper ? (ph_q - P_HALF) : ph_q;
  assign last  = (ph_q == P_LAST);
  assign mid   = (ph_q == P_MID);
endmodule

// File: rtl/bus_seq_ctx.sv
module bus_seq_ctx
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          last,
  input  logic          mid,
  input  logic          ext_fetch,
  input  logic [AW-1:0] fetch_addr,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-DW-1:0] port_hi,
  output cyc_e          kind,
  output logic          fon,
  output logic [DW-1:0] lo_q,
  output logic [AW-DW-1:0] hi_q,
  output logic [DW-1:0] wd_q
);
  localparam int HW = AW - DW;

  cyc_e          kind_q, kind_d;
  logic          fon_q, fon_d;
  logic [DW-1:0] lo_r, lo_d, wd_r, wd_d;
  logic [HW-1:0] hi_r, hi_d;
  logic          load_fetch;

  always_comb begin
    kind_d = kind_q;
    fon_d  = fon_q;
    lo_d   = lo_r;
    hi_d   = hi_r;
    wd_d   = wd_r;
    load_fetch = (last && !req_valid) || (mid && kind_q == CYC_FETCH);
    if (last && req_valid) begin
      kind_d = req_write ? CYC_WR : CYC_RD;
      fon_d  = 1'b0;
      lo_d   = req_addr[DW-1:0];
      hi_d   = req_wide ? req_addr[AW-1:DW] : port_hi;
      wd_d   = req_wdata;
    end else if (load_fetch) begin
      kind_d = CYC_FETCH;
      fon_d  = ext_fetch;
      lo_d   = fetch_addr[DW-1:0];
      hi_d   = fetch_addr[AW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      kind_q <= CYC_FETCH;
      fon_q  <= 1'b0;
      lo_r   <= '0;
      hi_r   <= '0;
      wd_r   <= '0;
    end else begin
      kind_q <= kind_d;
      fon_q  <= fon_d;
      lo_r   <= lo_d;
      hi_r   <= hi_d;
      wd_r   <= wd_d;
    end
  end

  assign kind = kind_q;
  assign fon  = fon_q;
  assign lo_q = lo_r;
  assign hi_q = hi_r;
  assign wd_q = wd_r;
endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
  import bus_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  phase_t        ph,
  input  phase_t        hp,
  input  logic          upper,
  input  cyc_e          kind,
  input  logic          fon,
  input  logic [DW-1:0] lo_q,
  input  logic [DW-1:0] wd_q,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          lo_oe,
  output logic [DW-1:0] lo_out
);
  logic is_fetch, half_live, addr_ph, stb_win, wr_drv;

  always_comb begin
    is_fetch  = (kind == CYC_FETCH);
    // a data cycle keeps only the first half's address phase
    half_live = !upper || is_fetch;
    ale       = half_live && (hp < P_ALE_OFF);
    addr_ph   = half_live && (hp < P_ADDR_OFF);
    psen_n    = !(is_fetch && fon && (hp >= P_ADDR_OFF) && (hp < P_PS_OFF));
    stb_win   = (ph >= P_STB_ON) && (ph < P_STB_OFF);
    rd_n      = !((kind == CYC_RD) && stb_win);
    wr_n      = !((kind == CYC_WR) && stb_win);
    wr_drv    = (kind == CYC_WR) && (ph >= P_ADDR_OFF);
    lo_oe     = addr_ph || wr_drv;
    lo_out    = addr_ph ? lo_q : wd_q;
  end
endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture
  import bus_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  input  phase_t        ph,
  input  phase_t        hp,
  input  cyc_e          kind,
  input  logic          fon,
  input  logic [DW-1:0] lo_in,
  output logic [DW-1:0] rdata,
  output logic          cap_valid,
  output logic          cap_code
);
  logic [DW-1:0] dat_q, dat_d;
  logic          v_q, v_d, c_q, c_d;
  logic          take_code, take_data;

  always_comb begin
    take_code = (kind == CYC_FETCH) && fon && (hp == P_PS_LAST);
    take_data = (kind == CYC_RD) && (ph == P_STB_LAST);
    dat_d = dat_q;
    c_d   = c_q;
    v_d   = take_code || take_data;
    if (take_code || take_data) begin
      dat_d = lo_in;
      c_d   = take_code;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      dat_q <= '0;
      v_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      dat_q <= dat_d;
      v_q   <= v_d;
      c_q   <= c_d;
    end
  end

  assign rdata     = dat_q;
  assign cap_valid = v_q;
  assign cap_code  = c_q;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_fetch,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_wide,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [AW-DW-1:0] port_hi,
  input  logic [DW-1:0]   lo_in,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   lo_out,
  output logic            lo_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0]   rdata,
  output logic            cap_valid,
  output logic            cap_code
);
  localparam int HW = AW - DW;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  phase_t        ph, hp;
  logic          upper, last, mid, fon;
  cyc_e          kind;
  logic [DW-1:0] lo_q, wd_q;
  logic [HW-1:0] hi_q;

  bus_seq_phase u_phase (
    .clk(clk), .rst_i(rst_i), .ph(ph), .hp(hp), .upper(upper), .last(last), .mid(mid)
  );

  bus_seq_ctx #(.AW(AW), .DW(DW)) u_ctx (
    .clk(clk), .rst_i(rst_i), .last(last), .mid(mid),
    .ext_fetch(ext_fetch), .fetch_addr(fetch_addr),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .port_hi(port_hi),
    .kind(kind), .fon(fon), .lo_q(lo_q), .hi_q(hi_q), .wd_q(wd_q)
  );

  bus_seq_strobe #(.DW(DW)) u_strobe (
    .ph(ph), .hp(hp), .upper(upper), .kind(kind), .fon(fon),
    .lo_q(lo_q), .wd_q(wd_q),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_oe(lo_oe), .lo_out(lo_out)
  );

  bus_seq_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_i(rst_i), .ph(ph), .hp(hp), .kind(kind), .fon(fon),
    .lo_in(lo_in), .rdata(rdata), .cap_valid(cap_valid), .cap_code(cap_code)
  );

  assign hi_out = hi_q;
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_i,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          lo_oe,
  input logic [HW-1:0] hi_out,
  input logic          cap_valid
);
  logic stb_idle;
  assign stb_idle = rd_n && wr_n;

  // R1
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ale) |=> ale ##1 !ale);

  // R3
  psen_vs_data_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !(!psen_n && !stb_idle));

  // R4
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !(!rd_n && !wr_n));

  // R4
  stb_lead_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(stb_idle) |-> $past(!ale) && $past(!ale, 2) && $past(!ale, 3) && $past(ale, 4));

  // R4
  stb_len_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(stb_idle) |-> $past(!stb_idle, 6) && $past(stb_idle, 7));

  // R5
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_n |-> !lo_oe);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(wr_n) |-> lo_oe);

  // R6
  hi_steady_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!stb_idle && $past(!stb_idle)) |-> $stable(hi_out));

  // R7
  cap_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cap_valid |-> psen_n && rd_n && $past(!psen_n || !rd_n));
endmodule

bind bus_seq bus_seq_chk #(.HW(AW - DW)) u_chk (
  .clk(clk), .rst_i(rst_i), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .lo_oe(lo_oe), .hi_out(hi_out), .cap_valid(cap_valid)
);

// File: tb/sim_bus_seq.sv
module sim_bus_seq;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic        rst_n, ext_fetch, req_valid, req_write, req_wide;
  logic [15:0] fetch_addr, req_addr;
  logic [7:0]  req_wdata, port_hi, lo_in;
  logic        ale, psen_n, rd_n, wr_n, lo_oe, cap_valid, cap_code;
  logic [7:0]  lo_out, hi_out, rdata;

  bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .ext_fetch(ext_fetch), .fetch_addr(fetch_addr),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .port_hi(port_hi), .lo_in(lo_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
    .lo_oe(lo_oe), .hi_out(hi_out), .rdata(rdata), .cap_valid(cap_valid),
    .cap_code(cap_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;
  int ph_tb = 0;
  logic [15:0] pc = 16'h0000;
  bit fon_g = 1'b0;
  // capture expected in phase 0 of the next cycle
  bit ecv = 1'b0;
  bit ecc = 1'b0;
  logic [7:0] ecd = 8'h00;

  always @(posedge clk) if (running) ph_tb <= (ph_tb == 11) ? 0 : ph_tb + 1;

  task automatic chk(input int act, input int exp, input string rq, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (phase %0d)", rq, what, act, exp, ph_tb);
    end
  endtask

  // Checks every phase of one machine cycle, starting at the negedge of phase 0.
  // k: 0 fetch, 1 read, 2 write.
  task automatic run_cycle(input int k, input bit fon, input logic [15:0] a0,
                           input logic [15:0] a1, input logic [7:0] wd,
                           input logic [7:0] b0, input logic [7:0] b1,
                           input logic [15:0] nx_a, input bit nx_fon);
    bit fe;
    fe = (k == 0);
    for (int p = 0; p < 12; p++) begin
      bit e_ale, e_ps, e_rd, e_wr, addrp, e_oe, e_cv, e_cc;
      logic [15:0] ha;
      logic [7:0]  e_cd;
      e_ale = (p < 2) || (fe && (p == 6 || p == 7));
      e_ps  = !(fe && fon && ((p >= 3 && p <= 5) || p >= 9));
      e_rd  = !(k == 1 && p >= 5 && p <= 10);
      e_wr  = !(k == 2 && p >= 5 && p <= 10);
      addrp = (p <= 2) || (fe && p >= 6 && p <= 8);
      e_oe  = addrp || (k == 2 && p >= 3);
      ha    = (fe && p >= 6) ? a1 : a0;
      chk(int'(ale), int'(e_ale), fe ? "R1" : "R3", "ale");
      chk(int'(psen_n), int'(e_ps), fe ? "R2" : "R3", "psen_n");
      chk(int'(rd_n), int'(e_rd), "R4", "rd_n");
      chk(int'(wr_n), int'(e_wr), "R4", "wr_n");
      chk(int'(lo_oe), int'(e_oe), "R5", "lo_oe");
      if (e_oe) chk(int'(lo_out), int'(addrp ? ha[7:0] : wd), (fe && p >= 6) ? "R9" : "R5", "lo_out");
      chk(int'(hi_out), int'(ha[15:8]), fe ? "R9" : "R6", "hi_out");
      e_cv = 1'b0; e_cc = 1'b0; e_cd = 8'h00;
      if (p == 0) begin e_cv = ecv; e_cc = ecc; e_cd = ecd; end
      else if (p == 6 && fe && fon) begin e_cv = 1'b1; e_cc = 1'b1; e_cd = b0; end
      else if (p == 11 && k == 1) begin e_cv = 1'b1; e_cc = 1'b0; e_cd = b0; end
      chk(int'(cap_valid), int'(e_cv), "R7", "cap_valid");
      if (e_cv) begin
        chk(int'(cap_code), int'(e_cc), "R7", "cap_code");
        chk(int'(rdata), int'(e_cd), "R7", "rdata");
      end
      if (fe && p == 3) lo_in = b0;
      if (fe && p == 9) lo_in = b1;
      if (k == 1 && p == 5) lo_in = b0;
      if (fe && p == 5) fetch_addr = a1;
      if (p == 8) begin fetch_addr = nx_a; ext_fetch = nx_fon; end
      @(negedge clk);
    end
    ecv = fe && fon; ecc = 1'b1; ecd = b1;
  endtask

  task automatic fetch_cycle(input logic [7:0] b0, input logic [7:0] b1);
    run_cycle(0, fon_g, pc, pc + 16'd1, 8'h00, b0, b1, pc + 16'd2, 1'b1);
    pc = pc + 16'd2;
    fon_g = 1'b1;
  endtask

  task automatic data_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] rb);
    run_cycle(k, 1'b0, a, a, wd, rb, 8'h00, pc, 1'b1);
  endtask

  task automatic arm(input bit wr, input bit wide, input logic [15:0] a,
                     input logic [7:0] wd, input logic [7:0] ph_reg);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_addr = a; req_wdata = wd; port_hi = ph_reg;
  endtask

  // R8: state held during reset
  task automatic t_reset;
    chk(int'(psen_n), 1, "R8", "psen_n in reset");
    chk(int'(rd_n), 1, "R8", "rd_n in reset");
    chk(int'(wr_n), 1, "R8", "wr_n in reset");
    chk(int'(cap_valid), 0, "R8", "cap_valid in reset");
    chk(int'(ale), 1, "R8", "ale in reset");
    chk(int'(lo_out), 0, "R8", "lo_out in reset");
    chk(int'(hi_out), 0, "R8", "hi_out in reset");
  endtask

  // R2: first cycle runs with external fetch disabled
  task automatic t_idle_fetch;
    fetch_cycle(8'h11, 8'h22);
  endtask

  // R1 R2 R7 R9: plain fetch stream
  task automatic t_fetch_stream;
    fetch_cycle(8'hA5, 8'h5A);
    fetch_cycle(8'h3C, 8'hC3);
  endtask

  // R3 R4 R6 R7: wide read; port register must not reach hi_out
  task automatic t_read_wide;
    arm(1'b0, 1'b1, 16'h8177, 8'h00, 8'hEE);
    fetch_cycle(8'h71, 8'h17);
    req_valid = 1'b0;
    data_cycle(1, 16'h8177, 8'h00, 8'h96);
  endtask

  // R6: 8-bit read puts the port register on hi_out
  task automatic t_read_narrow;
    arm(1'b0, 1'b0, 16'h4D2B, 8'h00, 8'hC4);
    fetch_cycle(8'h0F, 8'hF0);
    req_valid = 1'b0;
    data_cycle(1, 16'hC42B, 8'h00, 8'h69);
  endtask

  // R4 R5 R6: wide and narrow writes
  task automatic t_write;
    arm(1'b1, 1'b1, 16'h3A5C, 8'hB7, 8'h01);
    fetch_cycle(8'h12, 8'h34);
    req_valid = 1'b0;
    data_cycle(2, 16'h3A5C, 8'hB7, 8'h00);
    arm(1'b1, 1'b0, 16'hFFE4, 8'h4E, 8'h9D);
    fetch_cycle(8'h56, 8'h78);
    req_valid = 1'b0;
    data_cycle(2, 16'h9DE4, 8'h4E, 8'h00);
  endtask

  // R3 R4 R7: read then write in consecutive cycles, then back to fetching
  task automatic t_back_to_back;
    arm(1'b0, 1'b1, 16'h0203, 8'h00, 8'h00);
    fetch_cycle(8'h9A, 8'hBC);
    arm(1'b1, 1'b1, 16'h0405, 8'hD2, 8'h00);
    data_cycle(1, 16'h0203, 8'h00, 8'hE1);
    req_valid = 1'b0;
    data_cycle(2, 16'h0405, 8'hD2, 8'h00);
    fetch_cycle(8'h2D, 8'hD2);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_fetch = 1'b0; fetch_addr = 16'h0000;
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_addr = 16'h0000; req_wdata = 8'h00; port_hi = 8'h00; lo_in = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    running = 1'b1;
    t_idle_fetch();
    t_fetch_stream();
    t_read_wide();
    t_read_narrow();
    t_write();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule